// File: doc/BRIEF.md
# Bus Target Claim and Termination Controller

This block is the response side of a target on a shared, multiplexed address/data bus with a frame/ready handshake. It finds the address phase on the first clock where the frame signal is high after being low. It decides whether the address falls inside a programmed inclusive window `[base_i, limit_i]`. It then claims the transaction by raising the device-select output after a programmable delay. After the claim it paces the data phases with target-ready. It ends the transaction in one of three ways: normal completion, a disconnect at the edge of its window, or a target-abort when an I/O access has an enabled byte that falls outside the window.

All bus signals on the ports are active-high. An external pad stage does any inversion. When subtractive decoding is enabled, the block claims any access that it did not decode positively and that no other agent claimed within three clocks. A subtractive claim takes no boundary disconnect and no byte-lane abort. Configuration storage, the data path and parity belong to neighbouring blocks.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `devsel_o`, `trdy_o` and `stop_o` are low until a transaction is claimed.
- R2: Edge n is the first rising clock edge with `frame_i` high after a low. For a memory access (`io_i`=0) the decoded address is `{ad_i[31:2],2'b00}`; for an I/O access it is the full `ad_i`. If the decoded address is inside the window, `devsel_o` is high at sampling edge n+1, n+2 or n+3 for `sel_timing_i` = 00, 01 and 10 respectively. The value 11 is treated as 10.
- R3: An access outside the window with `sub_en_i`=0 leaves all three outputs low for the whole transaction.
- R4: An access outside the window with `sub_en_i`=1 is claimed (`devsel_o` high at edge n+4) only if `ext_devsel_i` is low at edges n+1, n+2 and n+3. If `ext_devsel_i` is high at any of those edges, the block does not claim. A subtractive claim never disconnects and never aborts.
- R5: `trdy_o` first rises one clock after `devsel_o` rises and is never high while `devsel_o` is low.
- R6: Once high, `devsel_o` stays high until the edge where `irdy_i` is high, `frame_i` is low and the phase ends. The only exception is target-abort.
- R7: On normal completion (a phase ends with `irdy_i`&`trdy_o` while `frame_i` is low), `devsel_o` and `trdy_o` both go low after that edge.
- R8: An I/O access treats each lane k (0..3) with `be_i[k]`=1 as byte address `{ad_i[31:2],k}`. If any such byte lies outside the window, then one clock after the claim `devsel_o` falls and `stop_o` rises, and `trdy_o` never rises. `stop_o` holds until the edge with `irdy_i` high and `frame_i` low. If every enabled byte is inside the window, the access completes normally.
- R9: Take a positively decoded burst. If a data phase ends with `frame_i` still high and the word address + 4 exceeds `limit_i`, then `trdy_o` falls and `stop_o` rises while `devsel_o` stays high. `stop_o` and `devsel_o` fall together after the edge with `irdy_i` high and `frame_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Master frame, active high |
| irdy_i | input | 1 | Master ready, active high |
| ad_i | input | 32 | Address during the address phase |
| be_i | input | 4 | Byte enables, one per lane, active high |
| io_i | input | 1 | 1 = I/O access, 0 = memory access |
| ext_devsel_i | input | 1 | Device select driven by any other agent |
| base_i | input | 32 | Lowest byte address of the window |
| limit_i | input | 32 | Highest byte address of the window |
| sel_timing_i | input | 2 | Claim delay: 00 fast, 01 medium, 10/11 slow |
| sub_en_i | input | 1 | Enable subtractive claiming |
| devsel_o | output | 1 | Device select |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Stop (disconnect or abort) |

## Verification
Every output is a register, so each response is visible at the first sampling point after the edge that caused it. Counted from the address edge n, the claim appears after 1, 2, 3 or 4 edges. Target-ready and the abort stop come one edge after the claim. The disconnect stop and every release come one edge after the completing phase. A behavioural model in the bench advances on the same edges, using elapsed-edge counts and integer addresses. The bench compares all three outputs with that model on each falling clock edge, halfway between edges, so each result is checked in the exact cycle it is due.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CLAIM, ST_XFER, ST_DISC, ST_ABORT
  } tgt_state_e;

  localparam logic [1:0] SEL_FAST = 2'b00;
  localparam logic [1:0] SEL_MED  = 2'b01;
endpackage

// File: rtl/pci_tgt_range_dec.sv
module pci_tgt_range_dec #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              io_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic              hit_o,
  output logic              lanes_ok_o
);
  localparam int LB = $clog2(LANES);

  logic [ADDR_W-1:0] word_a, probe_a;
  logic [LANES-1:0]  lane_bad;

  assign word_a  = {addr_i[ADDR_W-1:LB], {LB{1'b0}}};
  assign probe_a = io_i ? addr_i : word_a;
  assign hit_o   = (probe_a >= base_i) && (probe_a <= limit_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W-1:0] byte_a;
    assign byte_a      = {addr_i[ADDR_W-1:LB], LB'(k)};
    assign lane_bad[k] = be_i[k] && ((byte_a < base_i) || (byte_a > limit_i));
  end

  assign lanes_ok_o = ~|lane_bad;
endmodule

// File: rtl/pci_tgt_claim_timer.sv
module pci_tgt_claim_timer #(
  parameter int SUB_WAIT = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_i,
  input  logic       sub_i,
  input  logic [1:0] timing_i,
  input  logic       ext_i,
  output logic       claim_now_o,
  output logic       lost_o
);
  import pci_tgt_pkg::*;
  localparam int CW = $clog2(SUB_WAIT + 1) + 1;

  logic [CW-1:0] cnt_q, delay, target;

  always_comb begin
    unique case (timing_i)
      SEL_FAST: delay = CW'(1);
      SEL_MED:  delay = CW'(2);
      default:  delay = CW'(3);
    endcase
    target = sub_i ? CW'(SUB_WAIT) : delay - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(1);
    else if (run_i)   cnt_q <= cnt_q + CW'(1);
  end

  assign lost_o      = run_i && sub_i && ext_i;
  assign claim_now_o = (start_i && !sub_i && delay == CW'(1)) ||
                       (run_i && !lost_o && cnt_q == target);

  // R4: a subtractive claim never coincides with another agent's select
  a_r4_no_sub_over_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sub_i && claim_now_o) |-> !ext_i);
endmodule

// File: rtl/pci_tgt_burst.sv
module pci_tgt_burst #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic              past_end_o
);
  localparam int LB = $clog2(LANES);

  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W:0]   nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (load_i) cur_q <= {addr_i[ADDR_W-1:LB], {LB{1'b0}}};
    else if (step_i) cur_q <= cur_q + ADDR_W'(LANES);
  end

  // wide compare so a window ending at the top of the space does not wrap
  assign nxt        = {1'b0, cur_q} + (ADDR_W+1)'(LANES);
  assign past_end_o = nxt > {1'b0, limit_i};
endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl #(
  parameter int ADDR_W   = 32,
  parameter int LANES    = 4,
  parameter int SUB_WAIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              irdy_i,
  input  logic [ADDR_W-1:0] ad_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              io_i,
  input  logic              ext_devsel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [1:0]        sel_timing_i,
  input  logic              sub_en_i,
  output logic              devsel_o,
  output logic              trdy_o,
  output logic              stop_o
);
  import pci_tgt_pkg::*;

  tgt_state_e state_q;
  logic devsel_q, trdy_q, stop_q, frame_q, io_q, sub_q, ok_q;
  logic hit, lanes_ok, addr_start, claim_now, lost, past_end, take;

  assign addr_start = frame_i && !frame_q && state_q == ST_IDLE;
  assign take       = hit || sub_en_i;

  pci_tgt_range_dec #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .addr_i(ad_i), .be_i(be_i), .io_i(io_i), .base_i(base_i),
    .limit_i(limit_i), .hit_o(hit), .lanes_ok_o(lanes_ok));

  pci_tgt_claim_timer #(.SUB_WAIT(SUB_WAIT)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(addr_start && take), .run_i(state_q == ST_WAIT),
    .sub_i(addr_start ? !hit : sub_q), .timing_i(sel_timing_i),
    .ext_i(ext_devsel_i), .claim_now_o(claim_now), .lost_o(lost));

  pci_tgt_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bst (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(addr_start),
    .step_i(state_q == ST_XFER && irdy_i && trdy_q),
    .addr_i(ad_i), .limit_i(limit_i), .past_end_o(past_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      devsel_q <= 1'b0;
      trdy_q   <= 1'b0;
      stop_q   <= 1'b0;
      frame_q  <= 1'b0;
      io_q     <= 1'b0;
      sub_q    <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      frame_q <= frame_i;
      unique case (state_q)
        ST_IDLE: if (addr_start && take) begin
          io_q  <= io_i;
          ok_q  <= lanes_ok;
          sub_q <= !hit;
          if (claim_now) begin
            devsel_q <= 1'b1;
            state_q  <= ST_CLAIM;
          end else begin
            state_q  <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (lost) state_q <= ST_IDLE;
          else if (claim_now) begin
            devsel_q <= 1'b1;
            state_q  <= ST_CLAIM;
          end
        end
        ST_CLAIM: begin
          if (io_q && !sub_q && !ok_q) begin
            devsel_q <= 1'b0;
            stop_q   <= 1'b1;
            state_q  <= ST_ABORT;
          end else begin
            trdy_q  <= 1'b1;
            state_q <= ST_XFER;
          end
        end
        ST_XFER: if (irdy_i && trdy_q) begin
          if (!frame_i) begin
            devsel_q <= 1'b0;
            trdy_q   <= 1'b0;
            state_q  <= ST_IDLE;
          end else if (!sub_q && past_end) begin
            trdy_q  <= 1'b0;
            stop_q  <= 1'b1;
            state_q <= ST_DISC;
          end
        end
        ST_DISC: if (irdy_i && !frame_i) begin
          devsel_q <= 1'b0;
          stop_q   <= 1'b0;
          state_q  <= ST_IDLE;
        end
        ST_ABORT: if (irdy_i && !frame_i) begin
          stop_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign devsel_o = devsel_q;
  assign trdy_o   = trdy_q;
  assign stop_o   = stop_q;

  a_r5_trdy_needs_devsel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_o |-> devsel_o);
  a_r5_trdy_after_devsel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trdy_o) |-> $past(devsel_o));
  a_r6_devsel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(devsel_o) |-> ($past(irdy_i && !frame_i) || stop_o));
  a_r7_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(devsel_o) && !stop_o) |-> ($fell(trdy_o) || $fell(stop_o)));
  a_r8_abort_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !devsel_o) |-> !trdy_o);
  a_r9_disc_no_trdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && devsel_o) |-> !trdy_o);
endmodule

// File: tb/tb_pci_tgt_ctrl.sv
module tb_pci_tgt_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame = 0, irdy = 0, io = 0, ext = 0, sub_en = 0;
  logic [31:0] ad = '0, base = 32'h1000, limit = 32'h101F;
  logic [3:0]  be = 4'hF;
  logic [1:0]  tsel = 2'b00;
  logic devsel, trdy, stop;

  int compared = 0, mismatched = 0, cyc = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_tgt_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .irdy_i(irdy), .ad_i(ad),
    .be_i(be), .io_i(io), .ext_devsel_i(ext), .base_i(base), .limit_i(limit),
    .sel_timing_i(tsel), .sub_en_i(sub_en),
    .devsel_o(devsel), .trdy_o(trdy), .stop_o(stop));

  // behavioural reference: elapsed-edge counts and integer addresses
  int m_st, m_t, m_claim_t, m_d;
  bit m_sub, m_io, m_bad, m_fq, m_hit;
  bit e_dev, e_trdy, e_stop;
  longint m_w, m_a;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_fq = 0; e_dev = 0; e_trdy = 0; e_stop = 0;
    end else begin
      case (m_st)
        0: if (frame && !m_fq) begin
          m_a = longint'(ad);
          m_w = m_a - (m_a % 4);
          m_hit = io ? (m_a >= base && m_a <= limit) : (m_w >= base && m_w <= limit);
          m_bad = 0;
          for (int k = 0; k < 4; k++)
            if (be[k] && ((m_w + k) < base || (m_w + k) > limit)) m_bad = 1;
          m_d = (tsel == 2'b00) ? 1 : (tsel == 2'b01) ? 2 : 3;
          m_io = io; m_t = 0;
          if (m_hit) begin m_sub = 0; m_claim_t = m_d - 1; end
          else if (sub_en) begin m_sub = 1; m_claim_t = 3; end
          else m_claim_t = -1;
          if (m_claim_t == 0) begin e_dev = 1; m_st = 2; end
          else if (m_claim_t > 0) m_st = 1;
        end
        1: begin
          m_t++;
          if (m_sub && ext) m_st = 0;
          else if (m_t == m_claim_t) begin e_dev = 1; m_st = 2; end
        end
        2: if (m_io && !m_sub && m_bad) begin e_dev = 0; e_stop = 1; m_st = 5; end
           else begin e_trdy = 1; m_st = 3; end
        3: if (irdy && e_trdy) begin
          if (!frame) begin e_dev = 0; e_trdy = 0; m_st = 0; end
          else begin
            m_w += 4;
            if (!m_sub && m_w > limit) begin e_trdy = 0; e_stop = 1; m_st = 4; end
          end
        end
        default: if (irdy && !frame) begin e_dev = 0; e_stop = 0; m_st = 0; end
      endcase
      m_fq = frame;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(devsel === e_dev, cur_req, "devsel", int'(devsel), int'(e_dev));
    chk(trdy === e_trdy, cur_req, "trdy", int'(trdy), int'(e_trdy));
    chk(stop === e_stop, cur_req, "stop", int'(stop), int'(e_stop));
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  logic ph_done = 0;
  always @(posedge clk) ph_done <= irdy && (trdy || stop);

  bit saw_dev, saw_abort, saw_disc, saw_trdy;
  always @(negedge clk) begin
    if (devsel) saw_dev = 1;
    if (trdy) saw_trdy = 1;
    if (stop && !devsel) saw_abort = 1;
    if (stop && devsel) saw_disc = 1;
  end

  task automatic txn(input logic [31:0] a, input bit is_io, input logic [3:0] en,
                     input int n, input int ext_t);
    int left = n, cnt = 0;
    saw_dev = 0; saw_abort = 0; saw_disc = 0; saw_trdy = 0;
    @(negedge clk); frame = 1; ad = a; io = is_io; be = en; irdy = 0;
    forever begin
      @(negedge clk); cnt++;
      if (cnt == ext_t) ext = 1;
      if (ph_done) begin
        if (!frame) break;
        left--;
      end
      irdy = 1;
      if (stop) frame = 0;
      else frame = (left > 1);
      if (cnt > 8 && !devsel && !stop) break;
    end
    frame = 0; irdy = 0; ext = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!devsel && !trdy && !stop, "R1", "outputs in reset", int'({devsel, trdy, stop}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!devsel && !trdy && !stop, "R1", "outputs after reset", int'({devsel, trdy, stop}), 0);

    cur_req = "R2"; tsel = 2'b00; txn(32'h1004, 0, 4'hF, 1, 0);
    chk(saw_dev, "R2", "fast claim", int'(saw_dev), 1);
    cur_req = "R5"; tsel = 2'b01; txn(32'h1000, 0, 4'hF, 3, 0);
    chk(saw_trdy, "R5", "medium burst trdy", int'(saw_trdy), 1);
    cur_req = "R7"; tsel = 2'b10; txn(32'h1008, 0, 4'hF, 2, 0);
    chk(!saw_disc && !saw_abort, "R7", "slow normal end", int'(saw_disc), 0);
    cur_req = "R2"; tsel = 2'b11; txn(32'h101C, 0, 4'hF, 1, 0);
    chk(saw_dev, "R2", "last word, timing 11", int'(saw_dev), 1);

    cur_req = "R3"; tsel = 2'b00; txn(32'h0FFC, 0, 4'hF, 2, 0);
    chk(!saw_dev, "R3", "miss ignored", int'(saw_dev), 0);

    cur_req = "R4"; sub_en = 1; txn(32'h2000, 0, 4'hF, 3, 0);
    chk(saw_dev && !saw_disc, "R4", "subtractive claim, no disconnect", int'(saw_dev), 1);
    txn(32'h2000, 0, 4'hF, 2, 2);
    chk(!saw_dev, "R4", "other agent claimed", int'(saw_dev), 0);
    txn(32'h2000, 0, 4'hF, 2, 3);
    chk(!saw_dev, "R4", "other agent at third clock", int'(saw_dev), 0);
    sub_en = 0;

    cur_req = "R8"; txn(32'h101E, 1, 4'b0011, 1, 0);
    chk(saw_dev && !saw_abort, "R8", "io lanes inside", int'(saw_abort), 0);
    limit = 32'h101E; txn(32'h101E, 1, 4'b0100, 1, 0);
    chk(!saw_abort, "R8", "io lane at limit", int'(saw_abort), 0);
    txn(32'h101E, 1, 4'b1100, 1, 0);
    chk(saw_abort && !saw_trdy, "R8", "io lane above limit aborts", int'(saw_abort), 1);
    limit = 32'h101F; base = 32'h1001; tsel = 2'b01;
    txn(32'h1001, 1, 4'b0011, 1, 0);
    chk(saw_abort, "R8", "io lane below base aborts", int'(saw_abort), 1);
    base = 32'h1000;

    cur_req = "R9"; tsel = 2'b00; txn(32'h1018, 0, 4'hF, 4, 0);
    chk(saw_disc, "R9", "burst crosses limit", int'(saw_disc), 1);
    cur_req = "R6"; txn(32'h1018, 0, 4'hF, 2, 0);
    chk(!saw_disc, "R6", "burst ends at limit", int'(saw_disc), 0);

    cur_req = "R1"; rst_n = 0; @(negedge clk);
    chk(!devsel && !trdy && !stop, "R1", "second reset", int'({devsel, trdy, stop}), 0);
    rst_n = 1; repeat (2) @(negedge clk);
    finish_run();
  end
endmodule